// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a one-way word queue between two unrelated clock domains. A producer pushes 36-bit words on the write clock, and a consumer pulls them on the read clock. Each side sees only flags that are timed to its own clock. The write side has a room flag and an almost-full flag. The read side has a data-available flag and an almost-empty flag. Every flag is active-low in the sense that a low level means "stop" or "near the limit", and a high level means the side may proceed.

Each side learns about the other side's progress through a Gray-coded pointer that passes through a two-stage synchronizer. For that reason, a flag that is released by the other side's activity rises only on the second edge of its own clock after that activity. A flag that is lowered by its own side's activity falls at once. The almost thresholds are offsets supplied from outside. The almost-full offset is counted down from the depth, and the almost-empty offset is counted up from zero. A word already held in the output register counts as gone from storage.

A mode input chooses between two read styles. In standard mode a read enable fetches the next word into the output register. In fall-through mode the head word is presented on its own and the read enable consumes it.

Top module: `xdom_fifo`

## Requirements
- R1: `wr_afull_n` is low exactly when the write side's word count is at least DEPTH minus `y_ofs`. It is high when the count is at most DEPTH minus (`y_ofs`+1).
- R2: `rd_aempty_n` is low exactly when the read side's count of words in storage is `x_ofs` or fewer. A word already in the output register is not in storage.
- R3: `wr_room` is high while at least one of the DEPTH locations is free and low when none is. A write presented while `wr_room` is low is dropped, and that word never appears at the read port.
- R4: After a read frees a location, `wr_room` and `wr_afull_n` rise no earlier than the second rising `wclk` edge after that read, and they do rise on that edge. An accepted write lowers them on the same edge.
- R5: After a write, `rd_avail` and `rd_aempty_n` rise no earlier than the second rising `rclk` edge after that write, and they do rise on that edge.
- R6: In standard mode (`fwft`=0), `rd_avail` is high while storage holds a word. A `rd_en` sampled with `rd_avail` high loads the oldest word into `rd_data` on that edge. A `rd_en` sampled with `rd_avail` low changes nothing.
- R7: In fall-through mode (`fwft`=1), `rd_avail` is high while a word sits in the output register on `rd_data`. That word holds steady until `rd_en` is sampled high. On that edge the next stored word, if any, replaces it.
- R8: While `rst_n` is low, both pointers are cleared and `wr_room` and `rd_avail` are low. `wr_room` goes high on the first rising `wclk` edge after release.
- R9: Words leave in the order they were accepted, with their values intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| fwft | input | 1 | Read style: 0 standard, 1 fall-through; change only in reset |
| y_ofs | input | AW+1 | Almost-full offset, counted from full |
| x_ofs | input | AW+1 | Almost-empty offset, counted from empty |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Word to write |
| wr_room | output | 1 | High when a location is free |
| wr_afull_n | output | 1 | Low when the queue is almost full |
| rd_en | input | 1 | Read request or consume |
| rd_data | output | DW | Output register |
| rd_avail | output | 1 | Empty/output-ready flag, high when data is available |
| rd_aempty_n | output | 1 | Low when the queue is almost empty |

## Verification
A wrong pointer or synchronizer stage shows up first as a flag level that disagrees with a word-count model. The model runs the same two-edge delay on each side, so a lost or extra stage appears as a flag change one edge too early or too late, within two clocks of the causing access. A corrupt read pointer or output register shows up on the next word handed out, as a value or ordering mismatch against the record of accepted writes. Directed single-word transfers pin the exact edge on which each release happens. Random traffic with several offset pairs and both read styles covers the threshold boundaries.

// File: rtl/xtf_pkg.sv
package xtf_pkg;

   typedef enum logic {
      MODE_STD  = 1'b0,
      MODE_FWFT = 1'b1
   } xtf_mode_e;

endpackage

// File: rtl/xtf_sync.sv
module xtf_sync #(
   parameter int PW     = 4,
   parameter int STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] gray_in,
   output logic [PW-1:0] bin_out
);

   if (STAGES < 2) begin : g_bad_stages
      $error("xtf_sync: STAGES must be at least 2");
   end

   logic [PW-1:0] st [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) st[k] <= '0;
      end else begin
         st[0] <= gray_in;
         for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
      end
   end

   // Gray to binary: each bit is the parity of itself and all higher bits
   for (genvar i = 0; i < PW; i++) begin : g_g2b
      assign bin_out[i] = ^st[STAGES-1][PW-1:i];
   end

endmodule

// File: rtl/xtf_ram.sv
module xtf_ram #(
   parameter int AW = 3,
   parameter int DW = 36
) (
   input  logic          wclk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr,
   output logic [DW-1:0] rdata
);

   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata = mem[raddr];

endmodule

// File: rtl/xtf_wr_ctl.sv
module xtf_wr_ctl #(
   parameter int AW     = 3,
   parameter int STAGES = 2
) (
   input  logic          wclk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW:0]   y_ofs,
   input  logic [AW:0]   rd_gray,
   output logic [AW:0]   wr_gray,
   output logic [AW-1:0] wr_addr,
   output logic          wr_do,
   output logic          wr_room,
   output logic          wr_afull_n
);

   localparam int            PW    = AW + 1;
   localparam int            DEPTH = 1 << AW;
   localparam logic [PW-1:0] FULLV = PW'(DEPTH);
   localparam logic [PW:0]   DEPW  = (PW+1)'(DEPTH);
   localparam logic [PW-1:0] ONE   = PW'(1);

   logic [PW-1:0] wr_bin, wr_nx, rsync, lvl;
   logic          live;

   xtf_sync #(.PW(PW), .STAGES(STAGES)) u_rsync (
      .clk     (wclk),
      .rst_n   (rst_n),
      .gray_in (rd_gray),
      .bin_out (rsync)
   );

   assign lvl        = wr_bin - rsync;
   assign wr_room    = live && (lvl != FULLV);
   assign wr_afull_n = ({1'b0, lvl} + {1'b0, y_ofs}) < DEPW;
   assign wr_do      = wr_en && wr_room;
   assign wr_nx      = wr_do ? wr_bin + ONE : wr_bin;
   assign wr_addr    = wr_bin[AW-1:0];

   always_ff @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         wr_bin  <= '0;
         wr_gray <= '0;
         live    <= 1'b0;
      end else begin
         wr_bin  <= wr_nx;
         wr_gray <= wr_nx ^ (wr_nx >> 1);
         live    <= 1'b1;
      end
   end

   a_r3_hold_when_full: assert property (@(posedge wclk) disable iff (!rst_n)
      (wr_en && !wr_room) |=> (wr_bin == $past(wr_bin)));

   a_r3_level_bound: assert property (@(posedge wclk) disable iff (!rst_n)
      lvl <= FULLV);

   a_r4_room_rise: assert property (@(posedge wclk) disable iff (!rst_n)
      $rose(wr_room) |-> ($rose(live) || (rsync != $past(rsync))));

   a_r9_wgray_step: assert property (@(posedge wclk) disable iff (!rst_n)
      $countones(wr_gray ^ $past(wr_gray)) <= 1);

endmodule

// File: rtl/xtf_rd_ctl.sv
module xtf_rd_ctl
   import xtf_pkg::*;
#(
   parameter int AW     = 3,
   parameter int DW     = 36,
   parameter int STAGES = 2
) (
   input  logic          rclk,
   input  logic          rst_n,
   input  logic          fwft,
   input  logic          rd_en,
   input  logic [AW:0]   x_ofs,
   input  logic [AW:0]   wr_gray,
   input  logic [DW-1:0] mem_rdata,
   output logic [AW-1:0] rd_addr,
   output logic [AW:0]   rd_gray,
   output logic [DW-1:0] rd_q,
   output logic          rd_avail,
   output logic          rd_aempty_n
);

   localparam int            PW    = AW + 1;
   localparam int            DEPTH = 1 << AW;
   localparam logic [PW-1:0] FULLV = PW'(DEPTH);
   localparam logic [PW-1:0] ONE   = PW'(1);

   xtf_mode_e     mode;
   logic [PW-1:0] rd_bin, rd_nx, wsync, stored;
   logic          ov, ov_nx, has, load;

   xtf_sync #(.PW(PW), .STAGES(STAGES)) u_wsync (
      .clk     (rclk),
      .rst_n   (rst_n),
      .gray_in (wr_gray),
      .bin_out (wsync)
   );

   assign mode   = fwft ? MODE_FWFT : MODE_STD;
   assign stored = wsync - rd_bin;
   assign has    = (stored != '0);

   always_comb begin
      if (mode == MODE_FWFT) begin
         load  = has && (!ov || rd_en);
         ov_nx = load ? 1'b1 : (rd_en ? 1'b0 : ov);
      end else begin
         load  = has && rd_en;
         ov_nx = 1'b0;
      end
   end

   assign rd_nx       = load ? rd_bin + ONE : rd_bin;
   assign rd_addr     = rd_bin[AW-1:0];
   assign rd_avail    = (mode == MODE_FWFT) ? ov : has;
   assign rd_aempty_n = stored > x_ofs;

   always_ff @(posedge rclk or negedge rst_n) begin
      if (!rst_n) begin
         rd_bin  <= '0;
         rd_gray <= '0;
         ov      <= 1'b0;
         rd_q    <= '0;
      end else begin
         rd_bin  <= rd_nx;
         rd_gray <= rd_nx ^ (rd_nx >> 1);
         ov      <= ov_nx;
         if (load) rd_q <= mem_rdata;
      end
   end

   a_r6_no_read_empty: assert property (@(posedge rclk) disable iff (!rst_n)
      (!fwft && rd_en && !rd_avail) |=> (rd_bin == $past(rd_bin)));

   a_r5_avail_rise: assert property (@(posedge rclk) disable iff (!rst_n)
      (!fwft && $rose(rd_avail)) |-> (wsync != $past(wsync)));

   a_r7_head_hold: assert property (@(posedge rclk) disable iff (!rst_n)
      (fwft && rd_avail && !rd_en) |=> (rd_avail && $stable(rd_q)));

   a_r2_level_bound: assert property (@(posedge rclk) disable iff (!rst_n)
      stored <= FULLV);

   a_r9_rgray_step: assert property (@(posedge rclk) disable iff (!rst_n)
      $countones(rd_gray ^ $past(rd_gray)) <= 1);

endmodule

// File: rtl/xdom_fifo.sv
module xdom_fifo #(
   parameter int DW          = 36,
   parameter int AW          = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic          wclk,
   input  logic          rclk,
   input  logic          rst_n,
   input  logic          fwft,
   input  logic [AW:0]   y_ofs,
   input  logic [AW:0]   x_ofs,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   output logic          wr_room,
   output logic          wr_afull_n,
   input  logic          rd_en,
   output logic [DW-1:0] rd_data,
   output logic          rd_avail,
   output logic          rd_aempty_n
);

   if (DW < 1) begin : g_bad_dw
      $error("xdom_fifo: DW must be positive");
   end
   if (AW < 1 || AW > 12) begin : g_bad_aw
      $error("xdom_fifo: AW out of range 1..12");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("xdom_fifo: SYNC_STAGES must be at least 2");
   end

   logic [AW:0]   wr_gray, rd_gray;
   logic [AW-1:0] wr_addr, rd_addr;
   logic          wr_do;
   logic [DW-1:0] mem_rdata;

   xtf_wr_ctl #(.AW(AW), .STAGES(SYNC_STAGES)) u_wr (
      .wclk       (wclk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .y_ofs      (y_ofs),
      .rd_gray    (rd_gray),
      .wr_gray    (wr_gray),
      .wr_addr    (wr_addr),
      .wr_do      (wr_do),
      .wr_room    (wr_room),
      .wr_afull_n (wr_afull_n)
   );

   xtf_ram #(.AW(AW), .DW(DW)) u_ram (
      .wclk  (wclk),
      .we    (wr_do),
      .waddr (wr_addr),
      .wdata (wr_data),
      .raddr (rd_addr),
      .rdata (mem_rdata)
   );

   xtf_rd_ctl #(.AW(AW), .DW(DW), .STAGES(SYNC_STAGES)) u_rd (
      .rclk        (rclk),
      .rst_n       (rst_n),
      .fwft        (fwft),
      .rd_en       (rd_en),
      .x_ofs       (x_ofs),
      .wr_gray     (wr_gray),
      .mem_rdata   (mem_rdata),
      .rd_addr     (rd_addr),
      .rd_gray     (rd_gray),
      .rd_q        (rd_data),
      .rd_avail    (rd_avail),
      .rd_aempty_n (rd_aempty_n)
   );

endmodule

// File: tb/xdom_fifo_bench.sv
`timescale 1ns/100ps
module xdom_fifo_bench;

   localparam int DW    = 36;
   localparam int AW    = 3;
   localparam int DEPTH = 1 << AW;

   logic          wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0, fwft = 1'b0;
   logic [AW:0]   y_ofs = 4'd2, x_ofs = 4'd2;
   logic          wr_en = 1'b0, rd_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          wr_room, wr_afull_n, rd_avail, rd_aempty_n;
   logic [DW-1:0] rd_data;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   xdom_fifo #(.DW(DW), .AW(AW), .SYNC_STAGES(2)) u_xdom_fifo (
      .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .fwft(fwft),
      .y_ofs(y_ofs), .x_ofs(x_ofs),
      .wr_en(wr_en), .wr_data(wr_data), .wr_room(wr_room), .wr_afull_n(wr_afull_n),
      .rd_en(rd_en), .rd_data(rd_data), .rd_avail(rd_avail), .rd_aempty_n(rd_aempty_n)
   );

   // 125 MHz write clock (rising on 4+8m); read clock period 10, rising on odd ns
   always #4 wclk = ~wclk;
   initial begin
      #1;
      forever begin rclk = 1'b1; #5; rclk = 1'b0; #5; end
   end

   // ---------------- reference model: word counts with two-edge crossing ----
   int            m_wcnt = 0, m_rcnt = 0, rs1 = 0, rs2 = 0, ws1 = 0, ws2 = 0;
   bit            m_live = 1'b0, m_ov = 1'b0, m_dv = 1'b0;
   logic [DW-1:0] m_dout = '0;
   logic [DW-1:0] mdat [4096];

   function automatic bit f_room();
      return m_live && ((m_wcnt - rs2) < DEPTH);
   endfunction
   function automatic bit f_afull_n();
      return (m_wcnt - rs2) < (DEPTH - int'(y_ofs));
   endfunction
   function automatic bit f_avail();
      return fwft ? m_ov : ((ws2 - m_rcnt) > 0);
   endfunction
   function automatic bit f_aempty_n();
      return (ws2 - m_rcnt) > int'(x_ofs);
   endfunction

   always @(posedge wclk or negedge rst_n) begin
      if (!rst_n) begin
         m_wcnt <= 0; rs1 <= 0; rs2 <= 0; m_live <= 1'b0;
      end else begin
         m_live <= 1'b1;
         rs1    <= m_rcnt;
         rs2    <= rs1;
         if (wr_en && f_room()) begin
            mdat[m_wcnt % 4096] <= wr_data;
            m_wcnt <= m_wcnt + 1;
         end
      end
   end

   always @(posedge rclk or negedge rst_n) begin
      if (!rst_n) begin
         m_rcnt <= 0; ws1 <= 0; ws2 <= 0; m_ov <= 1'b0; m_dv <= 1'b0;
      end else begin : rd_model
         int mc;
         bit ld;
         mc  = ws2 - m_rcnt;
         ld  = fwft ? ((mc > 0) && (!m_ov || rd_en)) : ((mc > 0) && rd_en);
         ws1 <= m_wcnt;
         ws2 <= ws1;
         if (ld) begin
            m_dout <= mdat[m_rcnt % 4096];
            m_rcnt <= m_rcnt + 1;
            m_dv   <= 1'b1;
         end
         if (fwft) m_ov <= ld ? 1'b1 : (rd_en ? 1'b0 : m_ov);
      end
   end

   // ---------------- checking ------------------------------------------------
   task automatic chk1(string tag, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual=%0b expected=%0b", tag, $time, act, exp);
      end
   endtask

   task automatic chkd(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
      end
   endtask

   always @(negedge wclk) begin
      chk1("R3/R8 write room", wr_room, f_room());
      chk1("R1/R4 almost-full", wr_afull_n, f_afull_n());
   end

   always @(negedge rclk) begin
      chk1("R5/R6/R7 data available", rd_avail, f_avail());
      chk1("R2/R5 almost-empty", rd_aempty_n, f_aempty_n());
      if (fwft ? m_ov : m_dv) chkd("R9 word order/value", rd_data, m_dout);
   end

   // ---------------- stimulus ----------------------------------------------
   task automatic rand_word();
      logic [63:0] r64;
      r64     = {$urandom(), $urandom()};
      wr_data = r64[DW-1:0];
   endtask

   task automatic check_reset_state();
      chk1("R8 room low in reset", wr_room, 1'b0);
      chk1("R8 avail low in reset", rd_avail, 1'b0);
      chk1("R2 almost-empty low in reset", rd_aempty_n, 1'b0);
   endtask

   task automatic do_reset(logic mode, logic [AW:0] xo, logic [AW:0] yo);
      @(negedge wclk); #1.5;
      wr_en = 1'b0; rd_en = 1'b0; rst_n = 1'b0;
      fwft = mode; x_ofs = xo; y_ofs = yo;
      #20;
      check_reset_state();
      @(negedge wclk); #1.5;
      rst_n = 1'b1;
      @(posedge wclk); #0.5;
      chk1("R8 room rises on first edge after reset", wr_room, 1'b1);
   endtask

   task automatic run_rand(int ncyc, int pw, int pr);
      fork
         begin
            for (int i = 0; i < ncyc; i++) begin
               @(negedge wclk);
               wr_en = (($urandom() % 100) < pw);
               rand_word();
            end
            @(negedge wclk); wr_en = 1'b0;
         end
         begin
            for (int i = 0; i < (ncyc * 8) / 10; i++) begin
               @(negedge rclk);
               rd_en = (($urandom() % 100) < pr);
            end
            @(negedge rclk); rd_en = 1'b0;
         end
      join
      repeat (4) @(negedge rclk);
   endtask

   task automatic write_one(logic [DW-1:0] v);
      @(negedge wclk);
      wr_en = 1'b1; wr_data = v;
      @(posedge wclk); #0.5;
      wr_en = 1'b0;
   endtask

   task automatic read_one();
      @(negedge rclk); rd_en = 1'b1;
      @(posedge rclk); #0.5;
      rd_en = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd4711));
      #20;
      check_reset_state();
      @(negedge wclk); #1.5;
      rst_n = 1'b1;
      @(posedge wclk); #0.5;
      chk1("R8 room rises on first edge after reset", wr_room, 1'b1);

      // R5: one write, avail stays low after one read edge, high after two
      write_one(36'h9_8765_4321);
      @(posedge rclk); #0.5;
      chk1("R5 avail after first rclk edge", rd_avail, 1'b0);
      @(posedge rclk); #0.5;
      chk1("R5 avail after second rclk edge", rd_avail, 1'b1);
      // R6: standard read loads output register, storage then empty
      read_one();
      chkd("R6 standard read data", rd_data, 36'h9_8765_4321);
      chk1("R6 avail drops after last read", rd_avail, 1'b0);
      read_one();
      chkd("R6 read while empty keeps output", rd_data, 36'h9_8765_4321);

      // R3: overfill, extra writes are dropped
      for (int i = 0; i < DEPTH + 3; i++) begin
         @(negedge wclk); wr_en = 1'b1; wr_data = 36'(i + 16);
      end
      @(negedge wclk); wr_en = 1'b0;
      repeat (3) @(negedge wclk);
      chk1("R3 room low when full", wr_room, 1'b0);
      chk1("R1 almost-full low when full", wr_afull_n, 1'b0);

      // R4: one read frees a slot, room returns on the second wclk edge
      read_one();
      chkd("R9 first word after overfill", rd_data, 36'd16);
      @(posedge wclk); #0.5;
      chk1("R4 room after first wclk edge", wr_room, 1'b0);
      @(posedge wclk); #0.5;
      chk1("R4 room after second wclk edge", wr_room, 1'b1);

      // drain: only DEPTH words existed (R3 dropped ones never appear)
      for (int i = 1; i < DEPTH; i++) begin
         read_one();
         chkd("R3/R9 drained word", rd_data, 36'(i + 16));
      end
      repeat (3) @(negedge rclk);
      chk1("R3 nothing left after drain", rd_avail, 1'b0);

      run_rand(1500, 50, 55);
      run_rand(1000, 85, 30);
      run_rand(1000, 30, 85);

      // fall-through mode
      do_reset(1'b1, 4'd1, 4'd3);
      write_one(36'hA_5A5A_5A5A);
      repeat (3) @(posedge rclk);
      #0.5;
      chk1("R7 word presented without read", rd_avail, 1'b1);
      chkd("R7 head word on output", rd_data, 36'hA_5A5A_5A5A);
      repeat (3) @(posedge rclk);
      #0.5;
      chkd("R7 head word holds", rd_data, 36'hA_5A5A_5A5A);
      read_one();
      chk1("R7 consumed, nothing behind", rd_avail, 1'b0);
      run_rand(1500, 50, 55);
      run_rand(1000, 85, 30);
      run_rand(1000, 30, 85);

      do_reset(1'b0, 4'd0, 4'd0);
      run_rand(1200, 70, 60);
      do_reset(1'b1, 4'd7, 4'd7);
      run_rand(1200, 60, 70);
      do_reset(1'b0, 4'd4, 4'd5);
      run_rand(1200, 55, 55);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 8);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

endmodule